// File: doc/BRIEF.md
# Return-Address Stack with Error Trap

A fixed-depth hardware stack that holds program-counter values for a small processor core. The core pushes the return address on a call or interrupt entry and pops it on a return. The popped value appears combinationally on the output in the same cycle as the pop strobe, so the fetch logic can load the program counter at the next clock edge.

The stack never wraps. A push into a full stack and a pop from an empty stack are refused and latch sticky error flags. When the error-reset enable is set, an error also produces a one-cycle reset request for the system reset controller. That controller answers with a synchronous stack reset, which empties the stack but keeps the flags. Software can then read the flags to learn the cause of the reset. Only the power-on reset or an explicit clear strobe clears the flags.

A push and a pop in the same cycle replace the top entry. This covers a return that is immediately followed by a call.

Top module: `ret_stack`

## Requirements
- R1: After power-on reset (rst_ni low) the stack is empty, ovf_o, unf_o and rst_req_o are 0, and pop_addr_o is 0.
- R2: Values are returned last-in first-out. On a pop of a non-empty stack, pop_addr_o shows the top entry in the same cycle. In any cycle with no valid pop, pop_addr_o is 0.
- R3: Sixteen pushes are accepted without error. A push while sixteen entries are held sets ovf_o at the next edge and changes no stored entry.
- R4: A pop while the stack is empty sets unf_o at the next edge, drives pop_addr_o to 0, and leaves the stack empty.
- R5: ovf_o and unf_o stay set until flag_clr_i is high at a clock edge. A new error in the same cycle as flag_clr_i sets its flag.
- R6: With err_rst_en_i high, each error raises rst_req_o for exactly the one cycle after the error edge. With err_rst_en_i low, rst_req_o stays 0.
- R7: push_i and pop_i together on a non-empty stack output the old top entry, write the push value in its place, and keep the depth. On a full stack this is not an overflow. On an empty stack it counts as an underflow and nothing is stored.
- R8: sys_rst_i high at an edge empties the stack, takes priority over push and pop, and leaves ovf_o and unf_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_i | input | 1 | Synchronous stack reset from the reset controller |
| push_i | input | 1 | Push strobe |
| push_addr_i | input | 15 | Address to push |
| pop_i | input | 1 | Pop strobe |
| pop_addr_o | output | 15 | Popped address, 0 when no valid pop |
| flag_clr_i | input | 1 | Clears both error flags |
| err_rst_en_i | input | 1 | Enables the reset request on stack errors |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The clash that matters here is push and pop in the same cycle. The bench drives both strobes together on a partly filled stack, on a full stack and on an empty stack. It then pops the whole stack back and compares every value and flag against its own array model. A second clash is an error arriving in the same cycle as a flag clear, or in the same cycle as the stack reset. The bench provokes both and judges them from the flag and request outputs one edge later.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    return stk_op_e'({pop, push});
  endfunction
endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  stk_op_e          op_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             rd_ok_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             ovf_ev_o,
  output logic             unf_ev_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_m1;
  logic empty, full;

  assign empty  = (ptr_q == '0);
  assign full   = (ptr_q == PTR_W'(DEPTH));
  assign ptr_m1 = ptr_q - PTR_W'(1);

  always_comb begin
    ptr_d    = ptr_q;
    wr_en_o  = 1'b0;
    wr_idx_o = ptr_q[IDX_W-1:0];
    rd_ok_o  = 1'b0;
    rd_idx_o = ptr_m1[IDX_W-1:0];
    ovf_ev_o = 1'b0;
    unf_ev_o = 1'b0;
    if (sys_rst_i) begin
      ptr_d = '0;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          if (full) ovf_ev_o = 1'b1;
          else begin
            wr_en_o = 1'b1;
            ptr_d   = ptr_q + PTR_W'(1);
          end
        end
        OP_POP: begin
          if (empty) unf_ev_o = 1'b1;
          else begin
            rd_ok_o = 1'b1;
            ptr_d   = ptr_m1;
          end
        end
        OP_SWAP: begin
          if (empty) unf_ev_o = 1'b1;
          else begin
            rd_ok_o  = 1'b1;
            wr_en_o  = 1'b1;
            wr_idx_o = ptr_m1[IDX_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 15,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_ok_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_idx_i == IDX_W'(i))) slot_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = rd_ok_i ? slot_q[rd_idx_i] : '0;
endmodule

// File: rtl/ret_stack_flags.sv
module ret_stack_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_ev_i,
  input  logic unf_ev_i,
  input  logic flag_clr_i,
  input  logic err_rst_en_i,
  output logic ovf_o,
  output logic unf_o,
  output logic rst_req_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o     <= 1'b0;
      unf_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      ovf_o     <= ovf_ev_i | (ovf_o & ~flag_clr_i);
      unf_o     <= unf_ev_i | (unf_o & ~flag_clr_i);
      rst_req_o <= err_rst_en_i & (ovf_ev_i | unf_ev_i);
    end
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 15,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  input  logic              flag_clr_i,
  input  logic              err_rst_en_i,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              rst_req_o
);
  stk_op_e          op;
  logic             wr_en, rd_ok, ovf_ev, unf_ev;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign op = decode_op(push_i, pop_i);

  ret_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni, .sys_rst_i,
    .op_i     (op),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .rd_ok_o  (rd_ok),
    .rd_idx_o (rd_idx),
    .ovf_ev_o (ovf_ev),
    .unf_ev_o (unf_ev)
  );

  ret_stack_mem #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_mem (
    .clk_i,
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_addr_i),
    .rd_ok_i   (rd_ok),
    .rd_idx_i  (rd_idx),
    .rd_data_o (pop_addr_o)
  );

  ret_stack_flags u_flags (
    .clk_i, .rst_ni,
    .ovf_ev_i     (ovf_ev),
    .unf_ev_i     (unf_ev),
    .flag_clr_i,
    .err_rst_en_i,
    .ovf_o, .unf_o, .rst_req_o
  );
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_rst_i,
  input logic              push_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] pop_addr_o,
  input logic              flag_clr_i,
  input logic              err_rst_en_i,
  input logic              ovf_o,
  input logic              unf_o,
  input logic              rst_req_o
);
  a_r3_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(push_i && !pop_i && !sys_rst_i));

  a_r4_unf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unf_o) |-> $past(pop_i && !sys_rst_i));

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |-> (pop_addr_o == '0));

  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flag_clr_i) |=> ovf_o);

  a_r5_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_o && !flag_clr_i) |=> unf_o);

  a_r6_req_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(err_rst_en_i));

  a_r6_req_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (ovf_o || unf_o));

  a_r8_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && !flag_clr_i && unf_o) |=> unf_o);
endmodule

bind ret_stack ret_stack_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ret_stack_bench.sv
module ret_stack_bench;
  localparam int D = 16;

  logic        clk = 0, rst_n = 0;
  logic        sys_rst = 0, push = 0, pop = 0, clr = 0, en = 0;
  logic [14:0] pdat = '0;
  logic [14:0] q;
  logic        ovf, unf, req;
  int checks = 0, errors = 0;

  logic [14:0] model [D];
  int sp = 0;

  always #4 clk = ~clk;

  ret_stack u_ret_stack (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst),
    .push_i(push), .push_addr_i(pdat), .pop_i(pop), .pop_addr_o(q),
    .flag_clr_i(clr), .err_rst_en_i(en),
    .ovf_o(ovf), .unf_o(unf), .rst_req_o(req)
  );

  function automatic logic [14:0] pat(int k);
    return 15'((k * 1237 + 5) & 32'h7fff);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // called at negedge; returns popped value sampled before the edge
  task automatic cyc(input logic pu, input logic [14:0] d, input logic po,
                     input logic cl, input logic sr, output logic [14:0] got);
    push = pu; pdat = d; pop = po; clr = cl; sys_rst = sr;
    #1 got = q;
    @(negedge clk);
    push = 0; pop = 0; clr = 0; sys_rst = 0;
  endtask

  task automatic mpush(int k);
    logic [14:0] g;
    cyc(1, pat(k), 0, 0, 0, g);
    if (sp < D) begin model[sp] = pat(k); sp++; end
  endtask

  task automatic mpop_chk(string r);
    logic [14:0] g;
    logic [14:0] e;
    e = (sp > 0) ? model[sp-1] : '0;
    cyc(0, '0, 1, 0, 0, g);
    chk(r, {17'b0, g}, {17'b0, e});
    if (sp > 0) sp--;
  endtask

  task automatic clear_flags();
    logic [14:0] g;
    cyc(0, '0, 0, 1, 0, g);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [14:0] g;
    repeat (2) @(negedge clk);
    // R1
    chk("R1 ovf", ovf, 0); chk("R1 unf", unf, 0); chk("R1 req", req, 0);
    chk("R1 q", q, 0);
    rst_n = 1;
    @(negedge clk);

    for (int e = 0; e < 2; e++) begin
      en = e[0];
      for (int k = 0; k < D; k++) begin
        mpush(k + 40 * e);
        chk("R3 no ovf while filling", ovf, 0);
      end
      cyc(1, 15'h7abc, 0, 0, 0, g);
      chk("R3 ovf set", ovf, 1);
      chk("R6 req after ovf", req, e);
      @(negedge clk);
      chk("R6 req single cycle", req, 0);
      for (int k = 0; k < D; k++) mpop_chk("R2/R3 lifo contents");
      cyc(0, '0, 1, 0, 0, g);
      chk("R4 empty pop value", g, 0);
      chk("R4 unf set", unf, 1);
      chk("R6 req after unf", req, e);
      repeat (3) @(negedge clk);
      chk("R5 ovf sticky", ovf, 1);
      chk("R5 unf sticky", unf, 1);
      mpush(7); mpop_chk("R4 pointer unchanged");
      clear_flags();
      chk("R5 ovf cleared", ovf, 0); chk("R5 unf cleared", unf, 0);
    end
    en = 0;

    // R5 set beats clear
    cyc(0, '0, 1, 1, 0, g);
    chk("R5 set wins over clear", unf, 1);
    clear_flags();

    // R2 idle output
    mpush(3); #1 chk("R2 idle output zero", q, 0);
    @(negedge clk);

    // R7 replace on partial stack
    mpush(4);
    cyc(1, 15'h1234, 1, 0, 0, g);
    chk("R7 replace returns old top", g, pat(4));
    model[sp-1] = 15'h1234;
    mpop_chk("R7 replaced top");
    mpop_chk("R7 depth kept");
    cyc(0, '0, 1, 0, 0, g);
    chk("R7 stack empty after", unf, 1);
    clear_flags();

    // R7 replace on full
    for (int k = 0; k < D; k++) mpush(100 + k);
    cyc(1, 15'h0f0f, 1, 0, 0, g);
    chk("R7 full replace value", g, pat(115));
    chk("R7 full replace no ovf", ovf, 0);
    model[sp-1] = 15'h0f0f;
    for (int k = 0; k < D; k++) mpop_chk("R7 full stack drained");

    // R7 replace on empty
    en = 1;
    cyc(1, 15'h5555, 1, 0, 0, g);
    chk("R7 empty replace value", g, 0);
    chk("R7 empty replace unf", unf, 1);
    chk("R7 empty replace req", req, 1);
    clear_flags();
    cyc(0, '0, 1, 0, 0, g);
    chk("R7 nothing stored", g, 0);
    chk("R7 still empty", unf, 1);
    en = 0;

    // R8 stack reset keeps flags, empties stack, beats push
    for (int k = 0; k < 3; k++) mpush(200 + k);
    cyc(1, 15'h2222, 0, 0, 1, g);
    sp = 0;
    chk("R8 unf kept", unf, 1);
    clear_flags();
    cyc(0, '0, 1, 0, 0, g);
    chk("R8 stack emptied", g, 0);
    chk("R8 pop after reset underflows", unf, 1);
    cyc(0, '0, 1, 1, 1, g);
    chk("R8 reset beats pop", unf, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule